// File: doc/BRIEF.md
# Serial Port with Sticky Event Interrupt

This block is a byte-wide asynchronous serial port that sits on a simple 32-bit register bus. Software writes a byte to the data register to start a frame of one start bit, eight data bits (least significant first) and one stop bit. Software reads the same register to get the last byte that arrived. Each direction has its own baud counter, and both take their bit period from a shared divisor register. A completed transmit request and a completed reception each raise a sticky event flag in the status register. Software clears these flags by writing ones to them. A control register masks each flag onto one level-sensitive interrupt output.

Both serial engines are state machines with the states SER_IDLE, SER_START, SER_DATA and SER_STOP. The transmitter moves from SER_IDLE to SER_START when an accepted data write arrives. On each bit tick it moves from SER_START to SER_DATA, stays in SER_DATA until the last data bit has been sent, then moves to SER_STOP and returns to SER_IDLE. The receiver leaves SER_IDLE on a low synchronized line only when no receive event is pending. At the half-bit recheck it goes back to SER_IDLE if the line has returned high; otherwise it moves to SER_DATA. After the last data bit it moves to SER_STOP. At the stop-bit sample it goes to SER_IDLE and delivers the byte only if the line is high.

Top module: `uart_evt_top`

## Requirements
- R1: Registers are selected by byte address bits [4:2]. The index mapping is 0 data, 1 divisor, 2 status, 3 control, 4 debug. The divisor, control and debug registers read back every written bit. Indices 5 to 7 read zero.
- R2: After reset the data, divisor, control and debug registers read zero, the status register reads 0x1, the interrupt output is low and the serial output is high.
- R3: A data write accepted while the transmitter is idle sends the low byte on the serial output. The frame is a 0 start bit, eight data bits least significant first and a 1 stop bit, and each bit lasts divisor+1 clocks.
- R4: An accepted data write sets status bit 2, the transmit event.
- R5: Status bit 0 reads 0 while a frame is being sent and 1 otherwise. A data write made while it is 0 sends nothing and leaves the transmit event unchanged.
- R6: A well-formed received frame puts its byte in the data register and sets status bit 1, the receive event.
- R7: While the receive event is set, incoming frames are ignored and the data register keeps its byte.
- R8: A status write clears bit 1 and bit 2 wherever the written value has a 1. Bit 0 and every other bit ignore the write.
- R9: The interrupt output is high exactly when (control bit 0 and the receive event) or (control bit 1 and the transmit event). Control bit 0 is the receive enable and control bit 1 is the transmit enable.
- R10: A low pulse on the serial input that ends before half a bit period has passed is rejected. It sets no event and does not change the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write access, 0 for a read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_o | output | 1 | Level interrupt |
| ser_rx_i | input | 1 | Serial input, idle high |
| ser_tx_o | output | 1 | Serial output, idle high |

## Verification
The assertions assume that every bus access is word aligned, with the low two address bits at zero. They also assume that the divisor is changed only while both serial engines are idle. The bench drives only aligned addresses and changes the divisor only after waiting for all frames to finish. It also drives the serial input at exact multiples of the programmed bit period. Because of this, the receiver's mid-bit samples always fall inside the intended bit and no frame straddles a divisor change.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;
    localparam logic [2:0] IX_DATA = 3'd0;
    localparam logic [2:0] IX_DIV  = 3'd1;
    localparam logic [2:0] IX_STAT = 3'd2;
    localparam logic [2:0] IX_CTRL = 3'd3;
    localparam logic [2:0] IX_DBG  = 3'd4;

    localparam int ST_THRE = 0;
    localparam int ST_RXEV = 1;
    localparam int ST_TXEV = 2;
    localparam int CT_RXIE = 0;
    localparam int CT_TXIE = 1;

    typedef enum logic [1:0] {
        SER_IDLE  = 2'd0,
        SER_START = 2'd1,
        SER_DATA  = 2'd2,
        SER_STOP  = 2'd3
    } ser_state_e;
endpackage

// File: rtl/uart_evt_baud.sv
module uart_evt_baud #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] period,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q == '0)  cnt_q <= period;
        else                   cnt_q <= cnt_q - 1'b1;
    end

    assign tick = (cnt_q == '0) && !load;
endmodule

// File: rtl/uart_evt_tx.sv
module uart_evt_tx
    import uart_evt_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int FRAME_BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] din,
    input  logic [CNT_W-1:0]      div,
    output logic                  busy,
    output logic                  txd
);
    localparam int BC_W = $clog2(FRAME_BITS);

    ser_state_e            state_q, state_d;
    logic [FRAME_BITS-1:0] shreg_q;
    logic [BC_W-1:0]       bitcnt_q;
    logic                  tick;

    uart_evt_baud #(.CNT_W(CNT_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .load(start),
        .load_val(div), .period(div), .tick(tick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SER_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SER_IDLE:  if (start) state_d = SER_START;
            SER_START: if (tick)  state_d = SER_DATA;
            SER_DATA:  if (tick && bitcnt_q == BC_W'(FRAME_BITS-1)) state_d = SER_STOP;
            SER_STOP:  if (tick)  state_d = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q  <= '0;
            bitcnt_q <= '0;
        end else if (state_q == SER_IDLE && start) begin
            shreg_q  <= din;
            bitcnt_q <= '0;
        end else if (state_q == SER_DATA && tick) begin
            shreg_q  <= shreg_q >> 1;
            bitcnt_q <= bitcnt_q + 1'b1;
        end
    end

    always_comb begin
        unique case (state_q)
            SER_IDLE:  txd = 1'b1;
            SER_START: txd = 1'b0;
            SER_DATA:  txd = shreg_q[0];
            SER_STOP:  txd = 1'b1;
        endcase
    end

    assign busy = (state_q != SER_IDLE);
endmodule

// File: rtl/uart_evt_rx.sv
module uart_evt_rx
    import uart_evt_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int FRAME_BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rxd_raw,
    input  logic                  ready,
    input  logic [CNT_W-1:0]      div,
    output logic                  done,
    output logic [FRAME_BITS-1:0] dout
);
    localparam int BC_W = $clog2(FRAME_BITS);

    ser_state_e            state_q, state_d;
    logic                  sync1_q, sync2_q;
    logic [FRAME_BITS-1:0] shreg_q;
    logic [BC_W-1:0]       bitcnt_q;
    logic                  tick, load;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
        end else begin
            sync1_q <= rxd_raw;
            sync2_q <= sync1_q;
        end
    end

    assign load = (state_q == SER_IDLE) && !sync2_q && ready;

    uart_evt_baud #(.CNT_W(CNT_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .load(load),
        .load_val(div >> 1), .period(div), .tick(tick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SER_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SER_IDLE:  if (load) state_d = SER_START;
            SER_START: if (tick) state_d = sync2_q ? SER_IDLE : SER_DATA;
            SER_DATA:  if (tick && bitcnt_q == BC_W'(FRAME_BITS-1)) state_d = SER_STOP;
            SER_STOP:  if (tick) state_d = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q  <= '0;
            bitcnt_q <= '0;
        end else if (load) begin
            bitcnt_q <= '0;
        end else if (state_q == SER_DATA && tick) begin
            shreg_q  <= {sync2_q, shreg_q[FRAME_BITS-1:1]};
            bitcnt_q <= bitcnt_q + 1'b1;
        end
    end

    always_comb begin
        done = 1'b0;
        unique case (state_q)
            SER_IDLE, SER_START, SER_DATA: done = 1'b0;
            SER_STOP: done = tick && sync2_q;
        endcase
    end

    assign dout = shreg_q;
endmodule

// File: rtl/uart_evt_top.sv
module uart_evt_top
    import uart_evt_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 5,
    parameter int FRAME_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    input  logic              ser_rx_i,
    output logic              ser_tx_o
);
    localparam int IX_W = ADDR_W - 2;

    logic [IX_W-1:0]       widx;
    logic                  wr, tx_start, tx_busy, rx_done;
    logic [FRAME_BITS-1:0] rx_dout, data_rx_q;
    logic                  rx_evt_q, tx_evt_q;
    logic [DATA_W-1:0]     div_q, ctrl_q, dbg_q;

    assign widx     = bus_addr[ADDR_W-1:2];
    assign wr       = bus_sel && bus_we;
    assign tx_start = wr && (widx == IX_DATA) && !tx_busy;

    uart_evt_tx #(.CNT_W(DATA_W), .FRAME_BITS(FRAME_BITS)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_start),
        .din(bus_wdata[FRAME_BITS-1:0]), .div(div_q),
        .busy(tx_busy), .txd(ser_tx_o)
    );

    uart_evt_rx #(.CNT_W(DATA_W), .FRAME_BITS(FRAME_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n), .rxd_raw(ser_rx_i), .ready(!rx_evt_q),
        .div(div_q), .done(rx_done), .dout(rx_dout)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q     <= '0;
            ctrl_q    <= '0;
            dbg_q     <= '0;
            data_rx_q <= '0;
            rx_evt_q  <= 1'b0;
            tx_evt_q  <= 1'b0;
        end else begin
            if (wr && widx == IX_DIV)  div_q  <= bus_wdata;
            if (wr && widx == IX_CTRL) ctrl_q <= bus_wdata;
            if (wr && widx == IX_DBG)  dbg_q  <= bus_wdata;
            if (tx_start)
                tx_evt_q <= 1'b1;
            else if (wr && widx == IX_STAT && bus_wdata[ST_TXEV])
                tx_evt_q <= 1'b0;
            if (rx_done) begin
                rx_evt_q  <= 1'b1;
                data_rx_q <= rx_dout;
            end else if (wr && widx == IX_STAT && bus_wdata[ST_RXEV]) begin
                rx_evt_q <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (widx)
            IX_DATA: bus_rdata[FRAME_BITS-1:0] = data_rx_q;
            IX_DIV:  bus_rdata = div_q;
            IX_STAT: begin
                bus_rdata[ST_THRE] = !tx_busy;
                bus_rdata[ST_RXEV] = rx_evt_q;
                bus_rdata[ST_TXEV] = tx_evt_q;
            end
            IX_CTRL: bus_rdata = ctrl_q;
            IX_DBG:  bus_rdata = dbg_q;
            default: bus_rdata = '0;
        endcase
    end

    assign irq_o = (ctrl_q[CT_RXIE] && rx_evt_q) || (ctrl_q[CT_TXIE] && tx_evt_q);

    assert_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |-> (bus_addr[1:0] == 2'b00));
    assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !ser_tx_o);
    assert_drop_keeps_evt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && widx == IX_DATA && tx_busy) |=> (tx_evt_q == $past(tx_evt_q)));
    assert_rx_sets_evt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> rx_evt_q);
    assert_holdoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> !rx_evt_q);
    assert_w1c_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && widx == IX_STAT && bus_wdata[ST_TXEV]) |=> !tx_evt_q);
    assert_w1c_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && widx == IX_STAT && bus_wdata[ST_RXEV] && !rx_done) |=> !rx_evt_q);
    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (rx_evt_q || tx_evt_q));
endmodule

// File: tb/sim_uart_evt_top.sv
module sim_uart_evt_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, ser_tx_o;
    logic        ser_rx_i = 1'b1;

    int nchk = 0, nerr = 0;
    int cur_p = 1;
    bit finished = 0;
    logic [7:0] exp_tx[$];
    logic [31:0] rd;

    always #4 clk = ~clk;

    uart_evt_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .ser_rx_i(ser_rx_i), .ser_tx_o(ser_tx_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [2:0] idx, logic [31:0] val);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = {idx, 2'b00}; bus_wdata = val;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [2:0] idx, output logic [31:0] val);
        @(negedge clk);
        bus_addr = {idx, 2'b00};
        #1 val = bus_rdata;
    endtask

    task automatic set_div(int d);
        bus_write(3'd1, d);
        cur_p = d + 1;
    endtask

    // driver: accepted byte is queued for the monitor
    task automatic send_byte(logic [7:0] b);
        bus_write(3'd0, {24'h0, b});
        exp_tx.push_back(b);
    endtask

    task automatic wait_frame();
        repeat (11 * cur_p + 6) @(negedge clk);
    endtask

    task automatic rx_frame(logic [7:0] b);
        @(negedge clk);
        ser_rx_i = 1'b0;
        repeat (cur_p) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            ser_rx_i = b[i];
            repeat (cur_p) @(negedge clk);
        end
        ser_rx_i = 1'b1;
        repeat (cur_p + 6) @(negedge clk);
    endtask

    // monitor: decode frames on the serial output, compare against queue (R3)
    initial begin
        logic [7:0] got;
        @(posedge rst_n);
        forever begin
            @(negedge ser_tx_o);
            repeat (cur_p / 2) @(negedge clk);
            chk("R3 start bit", {31'h0, ser_tx_o}, 32'h0);
            for (int i = 0; i < 8; i++) begin
                repeat (cur_p) @(negedge clk);
                got[i] = ser_tx_o;
            end
            repeat (cur_p) @(negedge clk);
            chk("R3 stop bit", {31'h0, ser_tx_o}, 32'h1);
            if (exp_tx.size() == 0) begin
                nchk++; nerr++;
                $display("FAIL R3 unexpected frame actual %h expected none", got);
            end else begin
                chk("R3 frame byte", {24'h0, got}, {24'h0, exp_tx.pop_front()});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state
        bus_read(3'd0, rd); chk("R2 data", rd, 32'h0);
        bus_read(3'd1, rd); chk("R2 div", rd, 32'h0);
        bus_read(3'd2, rd); chk("R2 status", rd, 32'h1);
        bus_read(3'd3, rd); chk("R2 ctrl", rd, 32'h0);
        bus_read(3'd4, rd); chk("R2 debug", rd, 32'h0);
        chk("R2 irq", {31'h0, irq_o}, 32'h0);
        chk("R2 tx idle", {31'h0, ser_tx_o}, 32'h1);

        // R1 register read-back
        set_div(3);
        bus_read(3'd1, rd); chk("R1 div", rd, 32'h3);
        bus_write(3'd3, 32'h5A5A5A58);
        bus_read(3'd3, rd); chk("R1 ctrl", rd, 32'h5A5A5A58);
        bus_write(3'd4, 32'hDEADBEEF);
        bus_read(3'd4, rd); chk("R1 debug", rd, 32'hDEADBEEF);
        bus_read(3'd5, rd); chk("R1 unmapped", rd, 32'h0);
        bus_write(3'd3, 32'h0);

        // R3 R4 R5 transmit, busy flag and dropped write
        send_byte(8'h5A);
        bus_read(3'd2, rd); chk("R4 R5 status busy", rd, 32'h4);
        bus_write(3'd2, 32'h4);
        bus_write(3'd0, 32'hFF);
        bus_read(3'd2, rd); chk("R5 dropped write no event", rd, 32'h0);
        wait_frame();
        bus_read(3'd2, rd); chk("R5 idle again", rd, 32'h1);

        // R8 W1C, THRE ignores write
        send_byte(8'hC3);
        wait_frame();
        bus_read(3'd2, rd); chk("R4 event set", rd, 32'h5);
        bus_write(3'd2, 32'hFFFFFFF9);
        bus_read(3'd2, rd); chk("R8 no clear of tx bit", rd, 32'h5);
        bus_write(3'd2, 32'h4);
        bus_read(3'd2, rd); chk("R8 tx cleared", rd, 32'h1);
        send_byte(8'h01);
        wait_frame();

        // R9 interrupt enables (tx event set)
        bus_write(3'd3, 32'h1); @(negedge clk);
        chk("R9 rx-only enable", {31'h0, irq_o}, 32'h0);
        bus_write(3'd3, 32'h2); @(negedge clk);
        chk("R9 tx enable", {31'h0, irq_o}, 32'h1);
        bus_write(3'd2, 32'h4); @(negedge clk);
        chk("R9 cleared source", {31'h0, irq_o}, 32'h0);

        // R6 reception
        bus_write(3'd3, 32'h1);
        rx_frame(8'h96);
        bus_read(3'd2, rd); chk("R6 rx event", rd, 32'h3);
        bus_read(3'd0, rd); chk("R6 rx byte", rd, 32'h96);
        chk("R9 rx irq", {31'h0, irq_o}, 32'h1);

        // R7 hold-off
        rx_frame(8'h3C);
        bus_read(3'd0, rd); chk("R7 data held", rd, 32'h96);
        bus_write(3'd2, 32'h2);
        bus_read(3'd2, rd); chk("R8 rx cleared", rd, 32'h1);
        chk("R9 irq low", {31'h0, irq_o}, 32'h0);
        rx_frame(8'h3C);
        bus_read(3'd0, rd); chk("R6 second byte", rd, 32'h3C);
        bus_write(3'd2, 32'h2);

        // R10 glitch rejection at a longer period
        set_div(7);
        @(negedge clk); ser_rx_i = 1'b0;
        repeat (2) @(negedge clk); ser_rx_i = 1'b1;
        repeat (3 * cur_p) @(negedge clk);
        bus_read(3'd2, rd); chk("R10 no event", rd, 32'h1);
        bus_read(3'd0, rd); chk("R10 data kept", rd, 32'h3C);
        rx_frame(8'hE1);
        bus_read(3'd0, rd); chk("R6 byte at div 7", rd, 32'hE1);
        send_byte(8'h81);
        wait_frame();

        chk("R3 all frames seen", exp_tx.size(), 32'h0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule